// File: doc/BRIEF.md
# Load-use stall and operand bypass control

This block is the purely combinational hazard controller for a five-stage in-order integer pipeline with 32 architectural registers. It looks at the source register numbers in the fetch/decode and decode/execute pipeline registers, at the destination numbers and write enables of the two stages after execute, and at the memory-read flag of the instruction now in execute. From these it decides two things in the same cycle: whether the decode stage must wait one cycle behind a load, and where each ALU operand of the instruction in execute should come from.

When a load in execute writes a register that the instruction in decode reads, the stall output freezes the program counter and the fetch/decode register. The control word headed into decode/execute is forced to all zeros, so a no-op travels on in place of the held instruction. That single bubble is the whole cost; after it, the loaded value reaches the consumer through the bypass from the memory/writeback stage. Only the instruction directly behind the load is examined: a consumer two slots back is served by the bypass alone.

The two operand selects pick between the register file value, the result held in execute/memory, and the result held in memory/writeback. The younger producer (execute/memory) wins when both match, and register 0 or a stage that does not write the register file is never a bypass source.

Top module: `hz_ctrl`

## Requirements
- R1: `stall_o` is 1 whenever `idex_mem_rd_i` is 1 and `idex_rt_i` equals `ifid_rs_i` or `ifid_rt_i` (register 0 included).
- R2: `stall_o` is 0 whenever `idex_mem_rd_i` is 0 or neither decode source matches `idex_rt_i`; the destination fields of later stages never cause a stall, so a load two slots ahead of its consumer costs no bubble.
- R3: While `stall_o` is 1, `idex_ctrl_o` is all zeros; while it is 0, `idex_ctrl_o` equals `dec_ctrl_i`.
- R4: `fwd_a_o` is 2'b10 (take the execute/memory result) when `exmem_we_i` is 1, `exmem_rd_i` is nonzero and equals `idex_rs_i`.
- R5: `fwd_b_o` is 2'b10 under the same condition with `idex_rt_i` in place of `idex_rs_i`.
- R6: An operand select is 2'b01 (take the memory/writeback result) when `memwb_we_i` is 1, `memwb_rd_i` is nonzero and equals that operand's source, and the R4/R5 condition for that operand does not hold.
- R7: When both later stages match an operand's source and both are eligible, the select is 2'b10.
- R8: A stage whose destination is register 0 or whose write enable is 0 is never selected; with no eligible match the select is 2'b00 (register file), and 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs_i | input | 5 | First source register of the instruction in decode |
| ifid_rt_i | input | 5 | Second source register of the instruction in decode |
| idex_rs_i | input | 5 | First source register of the instruction in execute |
| idex_rt_i | input | 5 | Second source of the instruction in execute; load destination |
| idex_mem_rd_i | input | 1 | Instruction in execute reads data memory |
| exmem_rd_i | input | 5 | Destination register held in execute/memory |
| exmem_we_i | input | 1 | Execute/memory instruction writes the register file |
| memwb_rd_i | input | 5 | Destination register held in memory/writeback |
| memwb_we_i | input | 1 | Memory/writeback instruction writes the register file |
| dec_ctrl_i | input | 8 | Control word produced by the decoder |
| stall_o | output | 1 | Hold PC and fetch/decode, insert a bubble |
| idex_ctrl_o | output | 8 | Control word to load into decode/execute |
| fwd_a_o | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwd_b_o | output | 2 | Operand B source, same encoding |

## Verification
A table of hand-built cases separates a stall raised by the first decode source from one raised by the second, a matching register without a load, and a load whose consumer sits two slots back. Further entries set the two producers to agree, disagree, target register 0 or have writing disabled, which tells priority apart from eligibility. An exhaustive sweep over a small register range with every write-enable mix then compares both selects and the stall against a model built from the requirements, with distinct decoder control words showing whether the bubble clears or passes them.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF = 2'b00,
    FWD_WB = 2'b01,
    FWD_EX = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] dec_src0_i,
  input  logic [REG_W-1:0] dec_src1_i,
  input  logic [REG_W-1:0] ld_dst_i,
  input  logic             ld_vld_i,
  output logic             stall_o
);
  logic hit0, hit1;

  assign hit0    = (dec_src0_i == ld_dst_i);
  assign hit1    = (dec_src1_i == ld_dst_i);
  assign stall_o = ld_vld_i & (hit0 | hit1);
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output fwd_sel_e         sel_o
);
  logic ex_hit, wb_hit;

  // register 0 is hardwired and never a bypass source
  assign ex_hit = ex_we_i && (ex_rd_i != '0) && (ex_rd_i == src_i);
  assign wb_hit = wb_we_i && (wb_rd_i != '0) && (wb_rd_i == src_i);

  always_comb begin
    if (ex_hit)      sel_o = FWD_EX;
    else if (wb_hit) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end
endmodule

// File: rtl/hz_bubble.sv
module hz_bubble #(
  parameter int CTRL_W = 8
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              kill_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  assign ctrl_o = kill_i ? '0 : ctrl_i;
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int CTRL_W   = 8,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int N_OPS   = 2
) (
  input  logic [REG_W-1:0]  ifid_rs_i,
  input  logic [REG_W-1:0]  ifid_rt_i,
  input  logic [REG_W-1:0]  idex_rs_i,
  input  logic [REG_W-1:0]  idex_rt_i,
  input  logic              idex_mem_rd_i,
  input  logic [REG_W-1:0]  exmem_rd_i,
  input  logic              exmem_we_i,
  input  logic [REG_W-1:0]  memwb_rd_i,
  input  logic              memwb_we_i,
  input  logic [CTRL_W-1:0] dec_ctrl_i,
  output logic              stall_o,
  output logic [CTRL_W-1:0] idex_ctrl_o,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o
);
  logic [N_OPS-1:0][REG_W-1:0] op_src;
  fwd_sel_e                    op_sel [N_OPS];

  assign op_src[0] = idex_rs_i;
  assign op_src[1] = idex_rt_i;

  hz_load_use #(.REG_W(REG_W)) u_ldu (
    .dec_src0_i (ifid_rs_i),
    .dec_src1_i (ifid_rt_i),
    .ld_dst_i   (idex_rt_i),
    .ld_vld_i   (idex_mem_rd_i),
    .stall_o    (stall_o)
  );

  hz_bubble #(.CTRL_W(CTRL_W)) u_bub (
    .ctrl_i (dec_ctrl_i),
    .kill_i (stall_o),
    .ctrl_o (idex_ctrl_o)
  );

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    hz_fwd_sel #(.REG_W(REG_W)) u_sel (
      .src_i   (op_src[g]),
      .ex_rd_i (exmem_rd_i),
      .ex_we_i (exmem_we_i),
      .wb_rd_i (memwb_rd_i),
      .wb_we_i (memwb_we_i),
      .sel_o   (op_sel[g])
    );
  end

  assign fwd_a_o = op_sel[0];
  assign fwd_b_o = op_sel[1];
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int REG_W  = 5,
  parameter int CTRL_W = 8
) (
  input logic [REG_W-1:0]  ifid_rs_i,
  input logic [REG_W-1:0]  ifid_rt_i,
  input logic [REG_W-1:0]  idex_rs_i,
  input logic [REG_W-1:0]  idex_rt_i,
  input logic              idex_mem_rd_i,
  input logic [REG_W-1:0]  exmem_rd_i,
  input logic              exmem_we_i,
  input logic [REG_W-1:0]  memwb_rd_i,
  input logic              memwb_we_i,
  input logic [CTRL_W-1:0] dec_ctrl_i,
  input logic              stall_o,
  input logic [CTRL_W-1:0] idex_ctrl_o,
  input logic [1:0]        fwd_a_o,
  input logic [1:0]        fwd_b_o
);
  logic ex_ok_a, ex_ok_b, wb_ok_a, wb_ok_b;

  always_comb begin
    ex_ok_a = exmem_we_i && (exmem_rd_i != '0) && (exmem_rd_i == idex_rs_i);
    ex_ok_b = exmem_we_i && (exmem_rd_i != '0) && (exmem_rd_i == idex_rt_i);
    wb_ok_a = memwb_we_i && (memwb_rd_i != '0) && (memwb_rd_i == idex_rs_i);
    wb_ok_b = memwb_we_i && (memwb_rd_i != '0) && (memwb_rd_i == idex_rt_i);

    a_r2_stall_needs_load: assert (!stall_o || idex_mem_rd_i)
      else $error("stall without load");
    a_r2_stall_needs_match: assert (!stall_o || idex_rt_i == ifid_rs_i || idex_rt_i == ifid_rt_i)
      else $error("stall without dependency");
    a_r3_bubble_zero: assert (!stall_o || idex_ctrl_o == '0)
      else $error("bubble carries control");
    a_r3_pass_through: assert (stall_o || idex_ctrl_o == dec_ctrl_i)
      else $error("control altered without stall");
    a_r4_ex_a_eligible: assert (fwd_a_o != 2'b10 || ex_ok_a)
      else $error("operand A bypass from ineligible stage");
    a_r5_ex_b_eligible: assert (fwd_b_o != 2'b10 || ex_ok_b)
      else $error("operand B bypass from ineligible stage");
    a_r6_wb_a_eligible: assert (fwd_a_o != 2'b01 || wb_ok_a)
      else $error("operand A writeback bypass ineligible");
    a_r6_wb_b_eligible: assert (fwd_b_o != 2'b01 || wb_ok_b)
      else $error("operand B writeback bypass ineligible");
    a_r7_ex_priority_a: assert (fwd_a_o != 2'b01 || !ex_ok_a)
      else $error("operand A older producer won");
    a_r7_ex_priority_b: assert (fwd_b_o != 2'b01 || !ex_ok_b)
      else $error("operand B older producer won");
    a_r8_legal_a: assert (fwd_a_o != 2'b11) else $error("illegal select A");
    a_r8_legal_b: assert (fwd_b_o != 2'b11) else $error("illegal select B");
  end
endmodule

bind hz_ctrl hz_ctrl_chk #(.REG_W(REG_W), .CTRL_W(CTRL_W)) u_chk (.*);

// File: tb/sim_hz_ctrl.sv
module sim_hz_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;
  localparam int CW = 8;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [RW-1:0] ifid_rs, ifid_rt, idex_rs, idex_rt, exmem_rd, memwb_rd;
  logic          idex_mem_rd, exmem_we, memwb_we;
  logic [CW-1:0] dec_ctrl, idex_ctrl;
  logic          stall;
  logic [1:0]    fwd_a, fwd_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  hz_ctrl u0 (
    .ifid_rs_i(ifid_rs), .ifid_rt_i(ifid_rt),
    .idex_rs_i(idex_rs), .idex_rt_i(idex_rt), .idex_mem_rd_i(idex_mem_rd),
    .exmem_rd_i(exmem_rd), .exmem_we_i(exmem_we),
    .memwb_rd_i(memwb_rd), .memwb_we_i(memwb_we),
    .dec_ctrl_i(dec_ctrl), .stall_o(stall), .idex_ctrl_o(idex_ctrl),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b)
  );

  // {ifid_rs, ifid_rt, idex_rs, idex_rt, exmem_rd, memwb_rd, mem_rd, ex_we, wb_we, stall, a, b}
  localparam logic [37:0] VEC [NV] = '{
    {5'd1, 5'd2, 5'd3, 5'd2, 5'd0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00},
    {5'd5, 5'd9, 5'd3, 5'd5, 5'd0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00},
    {5'd5, 5'd9, 5'd3, 5'd5, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00},
    {5'd5, 5'd9, 5'd3, 5'd7, 5'd5, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00},
    {5'd0, 5'd0, 5'd4, 5'd6, 5'd4, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 2'b00},
    {5'd0, 5'd0, 5'd4, 5'd6, 5'd6, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b10},
    {5'd0, 5'd0, 5'd4, 5'd6, 5'd0, 5'd4, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 2'b00},
    {5'd0, 5'd0, 5'd4, 5'd6, 5'd4, 5'd4, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 2'b00},
    {5'd0, 5'd0, 5'd4, 5'd4, 5'd9, 5'd4, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 2'b01},
    {5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 2'b00},
    {5'd0, 5'd0, 5'd4, 5'd6, 5'd4, 5'd6, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00},
    {5'd0, 5'd0, 5'd4, 5'd6, 5'd4, 5'd4, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 2'b00},
    {5'd0, 5'd0, 5'd8, 5'd8, 5'd0, 5'd8, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 2'b01},
    {5'd3, 5'd3, 5'd3, 5'd3, 5'd3, 5'd3, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 2'b10}
  };
  string TAG [NV] = '{"R1 rt", "R1 rs", "R2 no load", "R2 two slots", "R4", "R5",
                      "R6", "R7", "R6 both ops", "R8 reg0", "R8 we off",
                      "R8/R6 ex disabled", "R8 ex reg0", "R1/R7 all match"};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_sel(input logic [RW-1:0] src, input logic [RW-1:0] er,
                                         input logic ew, input logic [RW-1:0] wr, input logic ww);
    if (ew && er != 0 && er == src) return 2'b10;
    if (ww && wr != 0 && wr == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic drive(input logic [37:0] v, input logic [CW-1:0] c);
    @(posedge clk);
    {ifid_rs, ifid_rt, idex_rs, idex_rt, exmem_rd, memwb_rd,
     idex_mem_rd, exmem_we, memwb_we} = v[37:5];
    dec_ctrl = c;
    @(negedge clk);
  endtask

  initial begin
    {ifid_rs, ifid_rt, idex_rs, idex_rt, exmem_rd, memwb_rd} = '0;
    {idex_mem_rd, exmem_we, memwb_we} = '0;
    dec_ctrl = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle stall", int'(stall), 0);
    chk("R8 idle fwd_a", int'(fwd_a), 0);
    chk("R8 idle fwd_b", int'(fwd_b), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], 8'hA5);
      chk(TAG[i], int'(stall), int'(VEC[i][4]));
      chk(TAG[i], int'(fwd_a), int'(VEC[i][3:2]));
      chk(TAG[i], int'(fwd_b), int'(VEC[i][1:0]));
      chk("R3", int'(idex_ctrl), VEC[i][4] ? 0 : 8'hA5);
    end

    // exhaustive sweep over registers 0..3 and all enable mixes
    for (int s = 0; s < 16; s++) begin
      for (int e = 0; e < 16; e++) begin
        for (int f = 0; f < 8; f++) begin
          logic [37:0] v;
          logic [1:0] ea, eb;
          logic es;
          logic [CW-1:0] c;
          v = '0;
          v[37:33] = RW'(s % 4);
          v[32:28] = RW'(f % 4);
          v[27:23] = RW'(s / 4);
          v[22:18] = RW'(e % 4);
          v[17:13] = RW'(e / 4);
          v[12:8]  = RW'((s + e) % 4);
          v[7] = f[2];
          v[6] = f[0];
          v[5] = f[1];
          c = CW'(s * 16 + e + 1);
          es = v[7] && (v[22:18] == v[37:33] || v[22:18] == v[32:28]);
          ea = ref_sel(v[27:23], v[17:13], v[6], v[12:8], v[5]);
          eb = ref_sel(v[22:18], v[17:13], v[6], v[12:8], v[5]);
          drive(v, c);
          chk("R1/R2 sweep", int'(stall), int'(es));
          chk("R4/R6/R7/R8 sweep A", int'(fwd_a), int'(ea));
          chk("R5/R6/R7/R8 sweep B", int'(fwd_b), int'(eb));
          chk("R3 sweep", int'(idex_ctrl), es ? 0 : int'(c));
        end
      end
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule